// File: doc/BRIEF.md
# Complement-Key Two-Stage Watchdog

This block supervises software with a down-counter clocked by a slow tick strobe, nominally 760 per second, produced elsewhere on the chip. Software services it through one 16-bit control word. The word carries a start count, a run/stop command and a 7-bit key. While the watchdog is armed, a write only takes effect if its key is the bitwise inverse of the key stored by the previous accepted write. A runaway loop that keeps writing the same value therefore cannot keep the watchdog alive.

When the count runs out, the block does not reset the system at once. It first raises a non-maskable interrupt and reloads a short grace count. If the grace count also runs out before a valid refresh, the block issues a single-cycle system-reset request to the reset controller. An accepted write withdraws the interrupt and returns the watchdog to its first stage.

Top module: `key_watchdog`

## Requirements
- R1: The control word places the start count in bits [8:0], the run command in bit 8 (it is also the count's top bit) and the key in bits [15:9]. The stored word reads back unchanged on `ctrl_rd`.
- R2: While the stored run bit (bit 8) is 1, a write whose key differs from the bitwise inverse of the stored 7-bit key is discarded. The stored word and the counter are left as they were.
- R3: An accepted write loads the counter from its count field. A count field of zero loads 256.
- R4: After an accepted write with bit 8 set, the counter falls by one on each cycle with `tick` high. After an accepted write with bit 8 clear, the counter holds its value.
- R5: An accepted write lowers `nmi` in the next cycle and returns the watchdog to its first stage.
- R6: When the running counter expires in the first stage (a tick arrives at count 1), `nmi` rises and the counter reloads with GRACE_TICKS (default 1). `nmi` then stays high until an accepted write or reset.
- R7: When the counter expires while `nmi` is high, `sys_rst_req` is high for exactly one cycle and the counter stops at 0.
- R8: Reset clears the stored word, the counter, `nmi` and `sys_rst_req`, and stops the watchdog.
- R9: When a write is accepted in the same cycle as a tick, the write wins. The counter takes the loaded value and the tick is not applied.
- R10: While the stored run bit is 0, a write with any key is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle count strobe, nominally 760 Hz |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word being written |
| nmi | output | 1 | Non-maskable interrupt, level |
| sys_rst_req | output | 1 | System-reset request, one-cycle pulse |
| ctrl_rd | output | 16 | Stored control word |
| cnt_rd | output | 9 | Current counter value |

## Verification
Two functions can fall in the same cycle: a software write and a tick strobe. The collision that matters is an accepted refresh landing in the cycle where a tick would expire the counter or decrement it. The bench provokes this with directed writes issued together with a tick, and with a long random phase where the tick is always high and writes arrive at random with right and wrong keys. Each cycle the outputs are compared against a behavioural model. In that model the accepted write takes precedence and a rejected write leaves the tick to act alone.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int CNT_W   = 9;
    localparam int KEY_W   = 7;
    localparam int CMD_BIT = 8;
    localparam int KEY_LSB = 9;
    localparam int CTRL_W  = KEY_LSB + KEY_W;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [CNT_W-1:0]  cnt;
        logic              run;
        logic              stage2;
        logic              rst_req;
    } wd_state_t;
endpackage

// File: rtl/wdog_field_split.sv
module wdog_field_split
    import wdog_pkg::*;
#(
    parameter int ZERO_LOAD = 1 << (CNT_W - 1)
) (
    input  logic [CTRL_W-1:0] word,
    output logic              cmd,
    output logic [KEY_W-1:0]  key,
    output logic [CNT_W-1:0]  load_val
);
    logic [CNT_W-1:0] raw_cnt;

    always_comb begin
        raw_cnt  = word[CNT_W-1:0];
        cmd      = word[CMD_BIT];
        key      = word[KEY_LSB +: KEY_W];
        load_val = (raw_cnt == '0) ? CNT_W'(ZERO_LOAD) : raw_cnt;
    end
endmodule

// File: rtl/wdog_key_gate.sv
module wdog_key_gate
    import wdog_pkg::*;
(
    input  logic              armed,
    input  logic [KEY_W-1:0]  stored_key,
    input  logic [KEY_W-1:0]  new_key,
    output logic              accept
);
    logic [KEY_W-1:0] want_key;

    always_comb begin
        want_key = ~stored_key;
        accept   = !armed || (new_key == want_key);
    end
endmodule

// File: rtl/key_watchdog.sv
module key_watchdog
    import wdog_pkg::*;
#(
    parameter int GRACE_TICKS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic              nmi,
    output logic              sys_rst_req,
    output logic [CTRL_W-1:0] ctrl_rd,
    output logic [CNT_W-1:0]  cnt_rd
);
    localparam logic [CNT_W-1:0] GRACE_LOAD = CNT_W'(GRACE_TICKS);

    wd_state_t st_q, st_d;

    logic             new_cmd, old_cmd;
    logic [KEY_W-1:0] new_key, old_key;
    logic [CNT_W-1:0] new_load, old_load;
    logic             wr_ok;

    wdog_field_split u_split_new (
        .word(wr_data), .cmd(new_cmd), .key(new_key), .load_val(new_load)
    );

    wdog_field_split u_split_old (
        .word(st_q.ctrl), .cmd(old_cmd), .key(old_key), .load_val(old_load)
    );

    wdog_key_gate u_gate (
        .armed(old_cmd), .stored_key(old_key), .new_key(new_key), .accept(wr_ok)
    );

    logic accepted;
    assign accepted = wr_en && wr_ok;

    always_comb begin
        st_d         = st_q;
        st_d.rst_req = 1'b0;
        if (accepted) begin
            st_d.ctrl   = wr_data;
            st_d.cnt    = new_load;
            st_d.run    = new_cmd;
            st_d.stage2 = 1'b0;
        end else if (tick && st_q.run) begin
            if (st_q.cnt > CNT_W'(1)) begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end else if (!st_q.stage2) begin
                st_d.stage2 = 1'b1;
                st_d.cnt    = GRACE_LOAD;
            end else begin
                st_d.rst_req = 1'b1;
                st_d.run     = 1'b0;
                st_d.cnt     = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign nmi         = st_q.stage2;
    assign sys_rst_req = st_q.rst_req;
    assign ctrl_rd     = st_q.ctrl;
    assign cnt_rd      = st_q.cnt;

    // unused by the datapath; kept visible for the armed-key view
    logic unused_old_load;
    assign unused_old_load = ^old_load;

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> !sys_rst_req); // R7
    AST_RST_AFTER_NMI: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> nmi); // R7
    AST_BAD_KEY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ok) |=> $stable(ctrl_rd)); // R2
    AST_REFRESH_DROPS_NMI: assert property (@(posedge clk) disable iff (!rst_n)
        accepted |=> !nmi); // R5
    AST_ZERO_LOADS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && wr_data[CNT_W-1:0] == '0) |=> cnt_rd == CNT_W'(256)); // R3
    AST_GRACE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi) |-> cnt_rd == GRACE_LOAD); // R6
    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !wr_en) |=> $stable(cnt_rd)); // R4
endmodule

// File: tb/tb_key_watchdog.sv
module tb_key_watchdog;
    logic        clk = 1'b0;
    logic        rst_n, tick, wr_en;
    logic [15:0] wr_data;
    logic        nmi, sys_rst_req;
    logic [15:0] ctrl_rd;
    logic [8:0]  cnt_rd;

    always #5 clk = ~clk;

    key_watchdog dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
        .nmi(nmi), .sys_rst_req(sys_rst_req), .ctrl_rd(ctrl_rd), .cnt_rd(cnt_rd)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int m_ctrl, m_cnt, m_run, m_nmi, m_rst;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int word(int key, int cmd, int cnt);
        return ((key & 127) << 9) | (cmd << 8) | (cnt & 255);
    endfunction

    function automatic void model_step(bit w, int data, bit t);
        bit take;
        int cnt_field;
        m_rst = 0;
        take = 1;
        if (((m_ctrl >> 8) & 1) == 1)
            take = (((data >> 9) & 127) == ((~(m_ctrl >> 9)) & 127));
        if (w && take) begin
            m_ctrl    = data & 16'hFFFF;
            cnt_field = data & 511;
            m_cnt     = (cnt_field == 0) ? 256 : cnt_field;
            m_run     = (data >> 8) & 1;
            m_nmi     = 0;
        end else if (t && m_run == 1) begin
            if (m_cnt >= 2) m_cnt = m_cnt - 1;
            else if (m_nmi == 0) begin m_nmi = 1; m_cnt = 1; end
            else begin m_rst = 1; m_run = 0; m_cnt = 0; end
        end
    endfunction

    task automatic compare_all();
        chk("R6 nmi", nmi, m_nmi);
        chk("R7 sys_rst_req", sys_rst_req, m_rst);
        chk("R2 ctrl_rd", ctrl_rd, m_ctrl);
        chk("R4 cnt_rd", cnt_rd, m_cnt);
    endtask

    task automatic cyc(bit w, int data, bit t);
        @(negedge clk);
        wr_en = w; wr_data = data[15:0]; tick = t;
        @(posedge clk);
        #1;
        model_step(w, data, t);
        compare_all();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog timeout actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 0; tick = 0; wr_en = 0; wr_data = '0;
        m_ctrl = 0; m_cnt = 0; m_run = 0; m_nmi = 0; m_rst = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R8 reset nmi", nmi, 0);
        chk("R8 reset sys_rst_req", sys_rst_req, 0);
        chk("R8 reset ctrl_rd", ctrl_rd, 0);
        chk("R8 reset cnt_rd", cnt_rd, 0);
        @(negedge clk);
        rst_n = 1;

        // R10: disabled, any key accepted; R1: count bits [8:0] with bit 8 = 0x100
        cyc(1, word(7'h2A, 1, 0), 0);
        chk("R1 ctrl layout", ctrl_rd, 16'h5500);
        chk("R1 count includes bit8", cnt_rd, 256);
        for (int i = 0; i < 10; i++) cyc(0, 0, 1);
        chk("R4 counted ticks", cnt_rd, 246);

        // R2: wrong key rejected, tick still acts
        cyc(1, word(7'h2A, 1, 5), 1);
        chk("R2 rejected write", ctrl_rd, 16'h5500);
        chk("R2 tick after reject", cnt_rd, 245);

        // R9: correct key with simultaneous tick, write wins
        cyc(1, word(7'h55, 1, 3), 1);
        chk("R9 write beats tick", cnt_rd, 259);

        for (int i = 0; i < 258; i++) cyc(0, 0, 1);
        chk("R4 reached one", cnt_rd, 1);
        cyc(0, 0, 1);
        chk("R6 nmi raised", nmi, 1);
        chk("R6 grace load", cnt_rd, 1);
        cyc(0, 0, 1);
        chk("R7 reset request", sys_rst_req, 1);
        cyc(0, 0, 1);
        chk("R7 request drops", sys_rst_req, 0);
        chk("R6 nmi held", nmi, 1);

        // R5 and R3: accepted stop write, count zero loads 256
        cyc(1, word(7'h2A, 0, 0), 0);
        chk("R5 nmi cleared", nmi, 0);
        chk("R3 zero loads 256", cnt_rd, 256);
        for (int i = 0; i < 5; i++) cyc(0, 0, 1);
        chk("R4 stopped holds", cnt_rd, 256);

        // R10: disarmed, unrelated key accepted
        cyc(1, word(7'h13, 0, 7), 0);
        chk("R10 any key", ctrl_rd, word(7'h13, 0, 7));
        chk("R10 count loaded", cnt_rd, 7);

        // random phase: tick always high, sparse writes with right or wrong key
        for (int i = 0; i < 4000; i++) begin
            bit w;
            int k, d;
            w = ($urandom % 150) == 0;
            k = ($urandom % 2 == 0) ? ((~(m_ctrl >> 9)) & 127) : ($urandom % 128);
            d = (k << 9) | ($urandom % 512);
            if ($urandom % 4 == 0) d = d & ~32'h100;
            else d = d | 32'h100;
            cyc(w, d, 1);
        end

        done = 1;
        summary();
        $finish;
    end
endmodule